// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer with Clock Output

This block is a counter of `WIDTH` bits (16 by default) paired with a reload register of the same width. Software programs it through a 4-bit control register, a 2-bit mode register and direct write ports for the count and reload values. All of these read back on dedicated output ports. The count advances on one of two sources. In timer use, the source is a tick from the surrounding core: once per machine cycle, or at the oscillator rate while the clock output is enabled. In counter use, the source is a falling edge on an external count pin.

The block has three behaviours. A plain up-counter reloads on overflow. A bidirectional counter takes its direction from an external pin. Counting down, it wraps to all-ones when it lands on the reload value, and it toggles an external flag on every wrap. The third behaviour is a clock generator: each reload toggles an output pin, which turns the reload period into a square wave. In that behaviour a falling edge on the direction pin can also raise the external flag. Capture selection is honoured only as a gate that stops counting.

Top module: `updn_reload_timer`

## Requirements
- R1: While the run bit (control bit 0) is 0, the count never changes except through a direct count write, whatever the mode and tick inputs.
- R2: With counter select (control bit 1) at 0 and clock output disabled, the count moves one step per cycle in which `mc_tick` is high. With counter select at 1, it moves one step per falling edge of `cnt_pin`. A falling edge means the pin is low now and was high in the registered sample taken one cycle earlier.
- R3: With both mode bits 0, the count increments. A step from all-ones loads the reload value and sets `ovf_flag`.
- R4: With bidirectional enable (mode bit 1) set, clock output disabled and `dir_pin` high, the count increments. A step from all-ones loads the reload value and sets `ovf_flag`.
- R5: With bidirectional enable set and `dir_pin` low, the count decrements. If the decremented value equals the reload value, the count becomes all-ones instead and `ovf_flag` is set.
- R6: In bidirectional mode, `ext_flag` inverts on every wrap, upward or downward.
- R7: With clock output enabled (mode bit 0, which overrides mode bit 1) in timer use, the count steps once per cycle with `osc_tick` high. Each wrap from all-ones loads the reload value and inverts `clk_out`, and `ovf_flag` is left unchanged.
- R8: With clock output enabled in counter use, steps come from `cnt_pin` falling edges, wraps still reload, and `clk_out` holds its value.
- R9: With clock output enabled, run set and external enable (control bit 3) set, a falling edge on `dir_pin` sets `ext_flag`. It is not set while external enable is 0.
- R10: While capture select (control bit 2) is 1, the count never steps.
- R11: A count write in the same cycle as a step loads the written value. When a flag clear and a flag event occur in the same cycle, the clear is applied first and the event second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control value: bit0 run, bit1 counter select, bit2 capture select, bit3 external enable |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode value: bit0 clock output enable, bit1 bidirectional enable |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | WIDTH | Count write value |
| rld_wr | input | 1 | Reload write strobe |
| rld_wdata | input | WIDTH | Reload write value |
| cnt_pin | input | 1 | External count input |
| dir_pin | input | 1 | Direction / external event input |
| mc_tick | input | 1 | Machine-cycle tick |
| osc_tick | input | 1 | Oscillator-rate tick |
| ovf_clr | input | 1 | Clears the overflow flag |
| ext_clr | input | 1 | Clears the external flag |
| cnt_rdata | output | WIDTH | Current count |
| rld_rdata | output | WIDTH | Current reload value |
| ctl_rdata | output | 4 | Control register readback |
| mode_rdata | output | 2 | Mode register readback |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External flag |
| clk_out | output | 1 | Square-wave clock output |

## Verification
The assertions assume that the tick inputs and pins are synchronous to `clk` and settle well before each rising edge. They also assume that a software write and the count it competes with are decided in the same cycle the write strobe is sampled. The bench drives every input only just after a falling clock edge and keeps each pin level for at least one full cycle. This way every edge seen by the detectors is a clean, single-cycle event. Tick inputs are held steady across whole cycles, and the number of steps is counted in cycles with the tick high.

// File: rtl/urt_pkg.sv
package urt_pkg;

    typedef enum logic [1:0] {
        MD_UP   = 2'd0,
        MD_UPDN = 2'd1,
        MD_CLKO = 2'd2
    } urt_mode_e;

    localparam int CTL_W      = 4;
    localparam int MODE_W     = 2;
    localparam int CTL_RUN    = 0;
    localparam int CTL_EXTCNT = 1;
    localparam int CTL_CAPT   = 2;
    localparam int CTL_EXTEN  = 3;
    localparam int MODE_CLKO  = 0;
    localparam int MODE_BIDIR = 1;

endpackage

// File: rtl/urt_fall_det.sv
module urt_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~pin;
endmodule

// File: rtl/urt_mode_dec.sv
module urt_mode_dec
    import urt_pkg::*;
(
    input  logic      run,
    input  logic      ext_cnt,
    input  logic      capt,
    input  logic      clko_en,
    input  logic      bidir_en,
    input  logic      mc_tick,
    input  logic      osc_tick,
    input  logic      cnt_fall,
    input  logic      dir_pin,
    output urt_mode_e mode,
    output logic      inc_en,
    output logic      count_up
);
    always_comb begin
        // clock output overrides the bidirectional selection
        if (clko_en)       mode = MD_CLKO;
        else if (bidir_en) mode = MD_UPDN;
        else               mode = MD_UP;

        count_up = (mode == MD_UPDN) ? dir_pin : 1'b1;

        inc_en = 1'b0;
        if (run && !capt) begin
            if (ext_cnt)              inc_en = cnt_fall;
            else if (mode == MD_CLKO) inc_en = osc_tick;
            else                      inc_en = mc_tick;
        end
    end
endmodule

// File: rtl/urt_step.sv
module urt_step #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] rld,
    input  logic             count_up,
    output logic [WIDTH-1:0] nxt,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    logic [WIDTH-1:0] dec_val;

    always_comb begin
        dec_val = cur - ONE;
        if (count_up) begin
            wrap = (cur == ALL_ONES);
            nxt  = wrap ? rld : (cur + ONE);
        end else begin
            wrap = (dec_val == rld);
            nxt  = wrap ? ALL_ONES : dec_val;
        end
    end
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
    import urt_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              cnt_wr,
    input  logic [WIDTH-1:0]  cnt_wdata,
    input  logic              rld_wr,
    input  logic [WIDTH-1:0]  rld_wdata,
    input  logic              cnt_pin,
    input  logic              dir_pin,
    input  logic              mc_tick,
    input  logic              osc_tick,
    input  logic              ovf_clr,
    input  logic              ext_clr,
    output logic [WIDTH-1:0]  cnt_rdata,
    output logic [WIDTH-1:0]  rld_rdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic [MODE_W-1:0] mode_rdata,
    output logic              ovf_flag,
    output logic              ext_flag,
    output logic              clk_out
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0]  cnt;
        logic [WIDTH-1:0]  rld;
        logic [CTL_W-1:0]  ctl;
        logic [MODE_W-1:0] mode;
        logic              ovf;
        logic              ext;
        logic              clk_out;
    } st_t;

    st_t st_d, st_q;

    logic             cnt_fall, dir_fall;
    urt_mode_e        mode_sel;
    logic             inc_en, count_up, wrap;
    logic [WIDTH-1:0] step_val;

    urt_fall_det u_cnt_fall (.clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(cnt_fall));
    urt_fall_det u_dir_fall (.clk(clk), .rst_n(rst_n), .pin(dir_pin), .fall(dir_fall));

    urt_mode_dec u_dec (
        .run      (st_q.ctl[CTL_RUN]),
        .ext_cnt  (st_q.ctl[CTL_EXTCNT]),
        .capt     (st_q.ctl[CTL_CAPT]),
        .clko_en  (st_q.mode[MODE_CLKO]),
        .bidir_en (st_q.mode[MODE_BIDIR]),
        .mc_tick  (mc_tick),
        .osc_tick (osc_tick),
        .cnt_fall (cnt_fall),
        .dir_pin  (dir_pin),
        .mode     (mode_sel),
        .inc_en   (inc_en),
        .count_up (count_up)
    );

    urt_step #(.WIDTH(WIDTH)) u_step (
        .cur      (st_q.cnt),
        .rld      (st_q.rld),
        .count_up (count_up),
        .nxt      (step_val),
        .wrap     (wrap)
    );

    logic step_wrap;
    assign step_wrap = inc_en & wrap;

    always_comb begin
        st_d = st_q;

        if (ctl_wr)  st_d.ctl  = ctl_wdata;
        if (mode_wr) st_d.mode = mode_wdata;
        if (rld_wr)  st_d.rld  = rld_wdata;

        // software write beats a step in the same cycle
        if (cnt_wr)      st_d.cnt = cnt_wdata;
        else if (inc_en) st_d.cnt = step_val;

        // flags: clear first, then apply the event
        if (ovf_clr) st_d.ovf = 1'b0;
        if (ext_clr) st_d.ext = 1'b0;

        if (step_wrap && mode_sel != MD_CLKO) st_d.ovf = 1'b1;
        if (step_wrap && mode_sel == MD_UPDN) st_d.ext = ~st_d.ext;

        if (mode_sel == MD_CLKO && st_q.ctl[CTL_RUN] &&
            st_q.ctl[CTL_EXTEN] && dir_fall)
            st_d.ext = 1'b1;

        if (step_wrap && mode_sel == MD_CLKO && !st_q.ctl[CTL_EXTCNT])
            st_d.clk_out = ~st_q.clk_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_rdata  = st_q.cnt;
    assign rld_rdata  = st_q.rld;
    assign ctl_rdata  = st_q.ctl;
    assign mode_rdata = st_q.mode;
    assign ovf_flag   = st_q.ovf;
    assign ext_flag   = st_q.ext;
    assign clk_out    = st_q.clk_out;

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctl[CTL_RUN] && !cnt_wr) |=> $stable(st_q.cnt)); // R1

    AST_CAPT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl[CTL_CAPT] && !cnt_wr) |=> $stable(st_q.cnt)); // R10

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MD_UP && inc_en && !cnt_wr && st_q.cnt == ALL_ONES)
        |=> (st_q.cnt == $past(st_q.rld)) && st_q.ovf); // R3

    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MD_UPDN && inc_en && !count_up && !cnt_wr &&
         (st_q.cnt - ONE) == st_q.rld)
        |=> (st_q.cnt == ALL_ONES) && st_q.ovf); // R5

    AST_CLKO_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MD_CLKO) |=> !$rose(st_q.ovf)); // R7

    AST_CLKOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != MD_CLKO || st_q.ctl[CTL_EXTCNT]) |=> $stable(st_q.clk_out)); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> st_q.cnt == $past(cnt_wdata)); // R11
endmodule

// File: tb/updn_reload_timer_tb.sv
module updn_reload_timer_tb;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, mode_wr = 0, cnt_wr = 0, rld_wr = 0;
    logic [3:0] ctl_wdata = '0;
    logic [1:0] mode_wdata = '0;
    logic [W-1:0] cnt_wdata = '0, rld_wdata = '0;
    logic cnt_pin = 0, dir_pin = 0, mc_tick = 0, osc_tick = 0;
    logic ovf_clr = 0, ext_clr = 0;
    logic [W-1:0] cnt_rdata, rld_rdata;
    logic [3:0] ctl_rdata;
    logic [1:0] mode_rdata;
    logic ovf_flag, ext_flag, clk_out;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    updn_reload_timer #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .rld_wr(rld_wr), .rld_wdata(rld_wdata),
        .cnt_pin(cnt_pin), .dir_pin(dir_pin),
        .mc_tick(mc_tick), .osc_tick(osc_tick),
        .ovf_clr(ovf_clr), .ext_clr(ext_clr),
        .cnt_rdata(cnt_rdata), .rld_rdata(rld_rdata),
        .ctl_rdata(ctl_rdata), .mode_rdata(mode_rdata),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag), .clk_out(clk_out)
    );

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic setup(input logic [3:0] ctl, input logic [1:0] md,
                         input logic [W-1:0] c, input logic [W-1:0] r);
        ctl_wr = 1; ctl_wdata = ctl; mode_wr = 1; mode_wdata = md;
        cnt_wr = 1; cnt_wdata = c; rld_wr = 1; rld_wdata = r;
        cyc();
        ctl_wr = 0; mode_wr = 0; cnt_wr = 0; rld_wr = 0;
    endtask

    task automatic clr_flags();
        ovf_clr = 1; ext_clr = 1; cyc(); ovf_clr = 0; ext_clr = 0;
    endtask

    task automatic mc_ticks(input int n);
        mc_tick = 1; cyc(n); mc_tick = 0;
    endtask

    task automatic osc_ticks(input int n);
        osc_tick = 1; cyc(n); osc_tick = 0;
    endtask

    task automatic pin_falls(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_pin = 1; cyc(); cnt_pin = 0; cyc();
        end
    endtask

    task automatic t_reset();
        chk("reset cnt", cnt_rdata, 0);
        chk("reset rld", rld_rdata, 0);
        chk("reset ctl", ctl_rdata, 0);
        chk("reset flags/clk", {ovf_flag, ext_flag, clk_out}, 0);
    endtask

    task automatic t_r1_halt();
        setup(4'h0, 2'b00, 16'h1234, 16'h0);
        mc_ticks(5); osc_ticks(3); pin_falls(2);
        chk("R1 halt up", cnt_rdata, 16'h1234);
        setup(4'h0, 2'b01, 16'h1234, 16'h0);
        osc_ticks(4);
        chk("R1 halt clko", cnt_rdata, 16'h1234);
    endtask

    task automatic t_r2_sources();
        setup(4'h1, 2'b00, 16'h0010, 16'h0);
        mc_ticks(3); cyc(2);
        chk("R2 timer ticks", cnt_rdata, 16'h0013);
        osc_ticks(4);
        chk("R2 osc ignored", cnt_rdata, 16'h0013);
        setup(4'h3, 2'b00, 16'h0020, 16'h0);
        mc_tick = 1;
        pin_falls(3);
        mc_tick = 0;
        chk("R2 pin falls", cnt_rdata, 16'h0023);
    endtask

    task automatic t_r3_up();
        clr_flags();
        setup(4'h1, 2'b00, 16'hFFFE, 16'hA000);
        mc_ticks(1);
        chk("R3 pre-wrap", {15'd0, ovf_flag, cnt_rdata}, {15'd0, 1'b0, 16'hFFFF});
        mc_ticks(1);
        chk("R3 reload", cnt_rdata, 16'hA000);
        chk("R3 ovf set", ovf_flag, 1);
        chk("R3 ext untouched", ext_flag, 0);
        clr_flags();
        chk("R3 ovf clear", ovf_flag, 0);
    endtask

    task automatic t_r4_r5_r6_updn();
        clr_flags();
        dir_pin = 1;
        setup(4'h1, 2'b10, 16'hFFFF, 16'h0005);
        mc_ticks(1);
        chk("R4 up reload", cnt_rdata, 16'h0005);
        chk("R4 ovf", ovf_flag, 1);
        chk("R6 ext toggled on", ext_flag, 1);
        ovf_clr = 1; cyc(); ovf_clr = 0;
        dir_pin = 0;
        setup(4'h1, 2'b10, 16'h0103, 16'h0100);
        mc_ticks(2);
        chk("R5 decrement", cnt_rdata, 16'h0101);
        chk("R5 no ovf yet", ovf_flag, 0);
        mc_ticks(1);
        chk("R5 down wrap", cnt_rdata, 16'hFFFF);
        chk("R5 ovf", ovf_flag, 1);
        chk("R6 ext toggled off", ext_flag, 0);
    endtask

    task automatic t_r7_clko();
        clr_flags();
        dir_pin = 0;
        setup(4'h1, 2'b01, 16'hFFFE, 16'hFFFD);
        mc_ticks(3);
        chk("R7 mc ignored", cnt_rdata, 16'hFFFE);
        osc_ticks(2);
        chk("R7 reload", cnt_rdata, 16'hFFFD);
        chk("R7 clk toggled", clk_out, 1);
        chk("R7 ovf untouched", ovf_flag, 0);
        osc_ticks(3);
        chk("R7 second wrap", {15'd0, clk_out, cnt_rdata}, {15'd0, 1'b0, 16'hFFFD});
    endtask

    task automatic t_r8_clko_counter();
        setup(4'h3, 2'b01, 16'hFFFF, 16'h0010);
        osc_tick = 1;
        pin_falls(1);
        osc_tick = 0;
        chk("R8 reload from pin", cnt_rdata, 16'h0010);
        chk("R8 clk held", clk_out, 0);
    endtask

    task automatic t_r9_ext_event();
        clr_flags();
        setup(4'h1, 2'b01, 16'h0, 16'h0);
        dir_pin = 1; cyc(); dir_pin = 0; cyc();
        chk("R9 no enable", ext_flag, 0);
        setup(4'h9, 2'b01, 16'h0, 16'h0);
        dir_pin = 1; cyc(); dir_pin = 0; cyc();
        chk("R9 event sets", ext_flag, 1);
    endtask

    task automatic t_r10_capt();
        setup(4'h5, 2'b00, 16'h0300, 16'h0);
        mc_ticks(4);
        chk("R10 up held", cnt_rdata, 16'h0300);
        setup(4'h5, 2'b01, 16'h0300, 16'h0);
        osc_ticks(4);
        chk("R10 clko held", cnt_rdata, 16'h0300);
    endtask

    task automatic t_r11_priority();
        setup(4'h1, 2'b00, 16'h0001, 16'h0);
        mc_tick = 1; cnt_wr = 1; cnt_wdata = 16'h4444;
        cyc();
        cnt_wr = 0; mc_tick = 0;
        chk("R11 write wins", cnt_rdata, 16'h4444);
        clr_flags();
        setup(4'h1, 2'b00, 16'hFFFF, 16'h0007);
        mc_tick = 1; ovf_clr = 1; cyc(); mc_tick = 0; ovf_clr = 0;
        chk("R11 set after clear", ovf_flag, 1);
    endtask

    initial begin
        cyc(2);
        rst_n = 1;
        cyc();
        t_reset();
        t_r1_halt();
        t_r2_sources();
        t_r3_up();
        t_r4_r5_r6_updn();
        t_r7_clko();
        t_r8_clko_counter();
        t_r9_ext_event();
        t_r10_capt();
        t_r11_priority();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule